// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is the slave end of a synchronous serial link that gives a host access to the control and result registers of a data converter. Every transaction opens with one instruction byte. That byte chooses read or write, a burst length of one to four bytes and a starting byte address. The data bytes follow, and the address moves by one after each byte. The registers behind the port are a 24-bit conversion result, a 32-bit command word, and two 24-bit calibration words (offset and gain). Every one of them can be read and written.

The serial clock, chip select and data pins are sampled by the block's system clock, so the serial clock must run well below it. Input bits are taken on the rising serial-clock edge, and the output bit changes on the falling edge. A parallel strobe loads a new conversion result.

Two command-word fields change how the port itself behaves: the read-direction bit and the write-only sync strobe, whose bit position returns the live data-ready input on a read. The other command bits, such as reference, bias, gain and rate, are only driven out for the analog side to use.

Top module: `cvt_serial_regif`

## Requirements
- R1: The instruction byte is shifted in MSB first on rising serial-clock edges. Bit 7 = 1 means read and 0 means write. Bits 6:5 hold the burst length minus one, so 0 to 3 gives 1 to 4 bytes. Bit 4 is ignored. Bits 3:0 are the starting byte address.
- R2: Once the burst has moved its stated number of bytes, the next byte on the link is decoded as a new instruction, even if chip select stays low.
- R3: Byte address map, with the most significant byte first inside each register: 0x0 to 0x2 are the result register, 0x4 to 0x7 are the command word, 0x8 to 0xA are the offset calibration and 0xC to 0xE are the gain calibration. Addresses 0x3, 0xB and 0xF read as 0x00, and writes to them change nothing.
- R4: Write bursts always step the address up by one. Read bursts step up by one, or down by one when the direction bit (command bit 27, bit 3 of address 0x4) is set. The address wraps within 4 bits.
- R5: Read data leaves on sdo MSB first. The first bit is valid after the falling edge that ends the instruction byte, and each later bit changes on a falling edge. sdo_en is high only while a read burst is in progress.
- R6: A written byte lands in its register on the falling serial-clock edge after that byte's eighth bit, and it shows on the register outputs before the next byte of the same burst starts.
- R7: After reset, the command word is 0x00000017, so the 13-bit rate field (bits 12:0) holds 23. The result, offset and gain registers are zero.
- R8: Command bit 24 is not stored. Writing it as 1 gives a sync_o pulse exactly one system clock wide, and writing it as 0 gives no pulse. Reading that bit position returns the drdy_i input.
- R9: Raising chip select abandons any partial byte or burst, writes nothing, and returns the port to waiting for an instruction.
- R10: A one-clock pulse on res_vld_i loads res_i into the result register, and the value can then be read back at addresses 0x0 to 0x2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_en | output | 1 | High while a read burst drives sdo |
| drdy_i | input | 1 | Live data-ready flag, returned in the sync bit position on reads |
| res_vld_i | input | 1 | Load strobe for the conversion result |
| res_i | input | 24 | Parallel conversion result |
| cmd_o | output | 32 | Command word, with bit 24 always 0 |
| ofs_cal_o | output | 24 | Offset calibration word |
| fs_cal_o | output | 24 | Gain calibration word |
| sync_o | output | 1 | One-clock sync strobe |

## Verification
Most faults in the transfer state show up inside one byte time. A wrong bit count or phase flag makes the port misread the next instruction. That gives wrong read bytes or register outputs for the rest of the burst, or leaves the next instruction treated as data. An address that steps the wrong way, wraps wrongly or ignores the direction bit shows on the second byte of a read burst. A write that lands late or in the wrong byte lane shows on the register outputs a few system clocks after that byte's last falling edge. The bench checks these outputs after every byte, not only after the whole burst. A stored sync bit or a pulse of the wrong width shows on cmd_o and sync_o within one clock.

// File: rtl/csr_serial_pkg.sv
package csr_serial_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_DOUT = 3'd1,
        RG_CMD  = 3'd2,
        RG_OFS  = 3'd3,
        RG_FS   = 3'd4
    } region_e;

    // byte lane index counts from the least significant byte (0 = LSB)
    typedef struct packed {
        region_e    rg;
        logic [1:0] lane;
    } loc_t;

    // position of the read-direction bit and of the sync/ready bit in the command word
    localparam int DIR_BIT  = 27;
    localparam int SYNC_BIT = 24;

    function automatic loc_t addr_decode(input logic [ADDR_W-1:0] a);
        loc_t l;
        l.rg   = RG_NONE;
        l.lane = 2'd0;
        case (a)
            4'h0: begin l.rg = RG_DOUT; l.lane = 2'd2; end
            4'h1: begin l.rg = RG_DOUT; l.lane = 2'd1; end
            4'h2: begin l.rg = RG_DOUT; l.lane = 2'd0; end
            4'h4: begin l.rg = RG_CMD;  l.lane = 2'd3; end
            4'h5: begin l.rg = RG_CMD;  l.lane = 2'd2; end
            4'h6: begin l.rg = RG_CMD;  l.lane = 2'd1; end
            4'h7: begin l.rg = RG_CMD;  l.lane = 2'd0; end
            4'h8: begin l.rg = RG_OFS;  l.lane = 2'd2; end
            4'h9: begin l.rg = RG_OFS;  l.lane = 2'd1; end
            4'hA: begin l.rg = RG_OFS;  l.lane = 2'd0; end
            4'hC: begin l.rg = RG_FS;   l.lane = 2'd2; end
            4'hD: begin l.rg = RG_FS;   l.lane = 2'd1; end
            4'hE: begin l.rg = RG_FS;   l.lane = 2'd0; end
            default: begin l.rg = RG_NONE; l.lane = 2'd0; end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/csr_edge_det.sv
module csr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic sclk;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        rise      = sclk & ~st_q.sclk;
        fall      = ~sclk & st_q.sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/csr_regbank.sv
module csr_regbank
    import csr_serial_pkg::*;
#(
    parameter int RATE_RESET = 23,
    parameter int RATE_W     = 13,
    parameter int CAL_W      = 24,
    parameter int CMD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              drdy_i,
    input  logic              res_vld_i,
    input  logic [CAL_W-1:0]  res_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [CAL_W-1:0]  ofs_o,
    output logic [CAL_W-1:0]  fs_o,
    output logic              sync_o,
    output logic              dir_down_o
);
    localparam logic [CMD_W-1:0] CMD_RST = CMD_W'(RATE_RESET) & ((CMD_W'(1) << RATE_W) - CMD_W'(1));
    localparam int TOP_LANE = (CMD_W / BYTE_W) - 1;

    typedef struct packed {
        logic [CAL_W-1:0] dout;
        logic [CMD_W-1:0] cmd;
        logic [CAL_W-1:0] ofs;
        logic [CAL_W-1:0] fs;
        logic             sync;
    } bank_t;

    bank_t bk_d, bk_q;
    loc_t  wl, rl;

    always_comb begin
        bk_d      = bk_q;
        bk_d.sync = 1'b0;
        wl        = addr_decode(wr_addr);
        if (res_vld_i) bk_d.dout = res_i;
        if (wr_en) begin
            case (wl.rg)
                RG_DOUT: bk_d.dout[BYTE_W*wl.lane +: BYTE_W] = wr_data;
                RG_CMD: begin
                    bk_d.cmd[BYTE_W*wl.lane +: BYTE_W] = wr_data;
                    if (int'(wl.lane) == TOP_LANE) begin
                        bk_d.cmd[SYNC_BIT] = 1'b0;
                        bk_d.sync          = wr_data[SYNC_BIT % BYTE_W];
                    end
                end
                RG_OFS:  bk_d.ofs[BYTE_W*wl.lane +: BYTE_W] = wr_data;
                RG_FS:   bk_d.fs[BYTE_W*wl.lane +: BYTE_W]  = wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rl      = addr_decode(rd_addr);
        rd_byte = '0;
        case (rl.rg)
            RG_DOUT: rd_byte = bk_q.dout[BYTE_W*rl.lane +: BYTE_W];
            RG_CMD: begin
                rd_byte = bk_q.cmd[BYTE_W*rl.lane +: BYTE_W];
                if (int'(rl.lane) == TOP_LANE) rd_byte[SYNC_BIT % BYTE_W] = drdy_i;
            end
            RG_OFS:  rd_byte = bk_q.ofs[BYTE_W*rl.lane +: BYTE_W];
            RG_FS:   rd_byte = bk_q.fs[BYTE_W*rl.lane +: BYTE_W];
            default: rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q      <= '0;
            bk_q.cmd  <= CMD_RST;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign cmd_o      = bk_q.cmd;
    assign ofs_o      = bk_q.ofs;
    assign fs_o       = bk_q.fs;
    assign sync_o     = bk_q.sync;
    assign dir_down_o = bk_q.cmd[DIR_BIT];

    // R8: the sync strobe never lasts longer than one clock
    p_sync_one_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);

    // R8: a write of the top command byte leaves the sync position clear
    p_sync_not_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'h4) |=> !cmd_o[SYNC_BIT]);

    // R3: writes to holes in the map change no register
    p_hole_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_decode(wr_addr).rg == RG_NONE && !res_vld_i)
        |=> ($stable(cmd_o) && $stable(ofs_o) && $stable(fs_o)));

endmodule

// File: rtl/csr_xfer_ctl.sv
module csr_xfer_ctl
    import csr_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              dir_down,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        phase_e            phase;
        logic              rd;
        logic [1:0]        left;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  bitcnt;
        logic              full;
        logic [BYTE_W-1:0] sh_in;
        logic [BYTE_W-1:0] sh_out;
    } xfer_t;

    xfer_t x_d, x_q;
    logic [ADDR_W-1:0] step;

    always_comb begin
        x_d     = x_q;
        wr_en   = 1'b0;
        step    = (x_q.rd && dir_down) ? x_q.addr - ADDR_W'(1) : x_q.addr + ADDR_W'(1);
        rd_addr = (x_q.phase == PH_INSTR) ? x_q.sh_in[ADDR_W-1:0] : step;
        if (cs_n) begin
            x_d.phase  = PH_INSTR;
            x_d.rd     = 1'b0;
            x_d.bitcnt = '0;
            x_d.full   = 1'b0;
            x_d.sh_out = '0;
        end else if (rise) begin
            x_d.sh_in  = {x_q.sh_in[BYTE_W-2:0], sdi};
            x_d.bitcnt = x_q.bitcnt + CNT_W'(1);
            if (x_q.bitcnt == CNT_W'(BYTE_W - 1)) x_d.full = 1'b1;
        end else if (fall) begin
            if (x_q.full) begin
                x_d.full = 1'b0;
                if (x_q.phase == PH_INSTR) begin
                    x_d.phase  = PH_DATA;
                    x_d.rd     = x_q.sh_in[7];
                    x_d.left   = x_q.sh_in[6:5];
                    x_d.addr   = x_q.sh_in[ADDR_W-1:0];
                    x_d.sh_out = x_q.sh_in[7] ? rd_byte : '0;
                end else begin
                    wr_en = ~x_q.rd;
                    if (x_q.left == 2'd0) begin
                        x_d.phase  = PH_INSTR;
                        x_d.rd     = 1'b0;
                        x_d.sh_out = '0;
                    end else begin
                        x_d.left   = x_q.left - 2'd1;
                        x_d.addr   = step;
                        x_d.sh_out = x_q.rd ? rd_byte : '0;
                    end
                end
            end else if (x_q.phase == PH_DATA && x_q.rd) begin
                x_d.sh_out = {x_q.sh_out[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign wr_addr = x_q.addr;
    assign wr_data = x_q.sh_in;
    assign sdo     = x_q.sh_out[BYTE_W-1];
    assign sdo_en  = (x_q.phase == PH_DATA) && x_q.rd && !cs_n;

    // R9: a deselect returns the port to instruction decode with no partial byte
    p_deselect_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (x_q.phase == PH_INSTR && x_q.bitcnt == '0 && !x_q.full));

    // R6: register writes happen only on a falling serial edge while selected
    p_write_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fall && !cs_n));

    // R2: the last byte of a burst hands the link back to instruction decode
    p_burst_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && fall && x_q.full && x_q.phase == PH_DATA && x_q.left == 2'd0)
        |=> x_q.phase == PH_INSTR);

    // R5: no read drive while waiting for an instruction
    p_quiet_in_instr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.phase == PH_INSTR) |-> !sdo_en);

endmodule

// File: rtl/cvt_serial_regif.sv
module cvt_serial_regif #(
    parameter int RATE_RESET = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_en,
    input  logic        drdy_i,
    input  logic        res_vld_i,
    input  logic [23:0] res_i,
    output logic [31:0] cmd_o,
    output logic [23:0] ofs_cal_o,
    output logic [23:0] fs_cal_o,
    output logic        sync_o
);
    import csr_serial_pkg::*;

    logic              rise, fall;
    logic              dir_down;
    logic [BYTE_W-1:0] rd_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;

    csr_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    csr_xfer_ctl u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .dir_down (dir_down),
        .rd_byte  (rd_byte),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdo      (sdo),
        .sdo_en   (sdo_en)
    );

    csr_regbank #(
        .RATE_RESET (RATE_RESET)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_byte    (rd_byte),
        .drdy_i     (drdy_i),
        .res_vld_i  (res_vld_i),
        .res_i      (res_i),
        .cmd_o      (cmd_o),
        .ofs_o      (ofs_cal_o),
        .fs_o       (fs_cal_o),
        .sync_o     (sync_o),
        .dir_down_o (dir_down)
    );

endmodule

// File: tb/cvt_serial_regif_bench.sv
module cvt_serial_regif_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo, sdo_en;
    logic        drdy_i = 1'b0;
    logic        res_vld_i = 1'b0;
    logic [23:0] res_i = '0;
    logic [31:0] cmd_o;
    logic [23:0] ofs_cal_o, fs_cal_o;
    logic        sync_o;

    int nchk = 0;
    int nfail = 0;
    int sync_cnt = 0;
    bit done = 1'b0;
    logic [7:0] mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (sync_o) sync_cnt <= sync_cnt + 1;

    cvt_serial_regif u_cvt_serial_regif (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .drdy_i(drdy_i), .res_vld_i(res_vld_i),
        .res_i(res_i), .cmd_o(cmd_o), .ofs_cal_o(ofs_cal_o),
        .fs_cal_o(fs_cal_o), .sync_o(sync_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit defd(input logic [3:0] a);
        return !(a == 4'h3 || a == 4'hB || a == 4'hF);
    endfunction

    function automatic logic [7:0] mrd(input logic [3:0] a);
        if (!defd(a)) return 8'h00;
        if (a == 4'h4) return {mem[4][7:1], drdy_i};
        return mem[a];
    endfunction

    task automatic check_regs(input string req);
        check(req, cmd_o, {mem[4], mem[5], mem[6], mem[7]});
        check(req, {8'h0, ofs_cal_o}, {8'h0, mem[8], mem[9], mem[10]});
        check(req, {8'h0, fs_cal_o}, {8'h0, mem[12], mem[13], mem[14]});
    endtask

    task automatic sbit(input logic b, output logic o);
        sdi = b;
        repeat (HALF) @(negedge clk);
        o = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic o;
            sbit(v[i], o);
            r[i] = o;
        end
    endtask

    // one transaction; the model and the checks follow every byte
    task automatic xact(input bit rd, input int n, input logic [3:0] a0,
                        input logic [31:0] wd, input bit keep);
        logic [3:0] a;
        logic [7:0] r, b;
        cs_n = 1'b0;
        send_byte({rd, 2'(n - 1), 1'b0, a0}, r);
        a = a0;
        for (int k = 0; k < n; k++) begin
            if (!rd) begin
                b = wd[31 - 8*k -: 8];
                send_byte(b, r);
                repeat (2) @(negedge clk);
                if (defd(a)) mem[a] = (a == 4'h4) ? {b[7:1], 1'b0} : b;
                check("R6 per-byte write R3 map R4 ascend", cmd_o, {mem[4], mem[5], mem[6], mem[7]});
                check("R6 per-byte write R3 map", {8'h0, ofs_cal_o, fs_cal_o[23:16]},
                      {8'h0, mem[8], mem[9], mem[10], mem[12]});
                check("R6 per-byte write R3 map", {16'h0, fs_cal_o[15:0]}, {16'h0, mem[13], mem[14]});
                a = a + 4'd1;
            end else begin
                send_byte(8'h00, r);
                check("R1 R5 read R3 map R4 step", {24'h0, r}, {24'h0, mrd(a)});
                a = mem[4][3] ? a - 4'd1 : a + 4'd1;
            end
        end
        if (!keep) begin
            repeat (2) @(negedge clk);
            cs_n = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        mem[7] = 8'h17;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 reset values
        check("R7 reset cmd", cmd_o, 32'h0000_0017);
        check("R7 reset cal", {8'h0, ofs_cal_o}, 32'h0);
        check("R7 reset cal", {8'h0, fs_cal_o}, 32'h0);
        check("R5 idle sdo_en", {31'h0, sdo_en}, 32'h0);
        check("R8 idle sync", {31'h0, sync_o}, 32'h0);
        xact(1'b1, 4, 4'h4, 32'h0, 1'b0);
        xact(1'b1, 3, 4'h0, 32'h0, 1'b0);

        // R1 R3 R4 R6: every length from every start address, write then read back
        for (int n = 1; n <= 4; n++) begin
            for (int a = 0; a < 16; a++) begin
                logic [31:0] wd;
                for (int k = 0; k < 4; k++)
                    wd[31 - 8*k -: 8] = 8'(a*16 + n*5 + k*3 + 8'h2B);
                xact(1'b0, n, 4'(a), wd, 1'b0);
                xact(1'b1, n, 4'(a), 32'h0, 1'b0);
            end
        end

        // R4 downward reads: set the direction bit, sweep all reads again
        xact(1'b0, 1, 4'h4, 32'h0800_0000, 1'b0);
        check("R4 dir bit stored", {31'h0, cmd_o[27]}, 32'h1);
        for (int n = 1; n <= 4; n++)
            for (int a = 0; a < 16; a++)
                xact(1'b1, n, 4'(a), 32'h0, 1'b0);
        // R4 writes still ascend with the direction bit set
        xact(1'b0, 3, 4'h8, 32'h1122_3300, 1'b0);
        check("R4 write ascends under dir bit", {8'h0, ofs_cal_o}, 32'h0011_2233);
        xact(1'b0, 1, 4'h4, 32'h0, 1'b0);

        // R8 sync strobe and live ready bit
        sync_cnt = 0;
        xact(1'b0, 1, 4'h4, 32'h0100_0000, 1'b0);
        check("R8 sync one clock", sync_cnt, 32'd1);
        check("R8 sync bit not stored", {31'h0, cmd_o[24]}, 32'h0);
        sync_cnt = 0;
        xact(1'b0, 1, 4'h4, 32'h0000_0000, 1'b0);
        check("R8 no sync on zero", sync_cnt, 32'd0);
        drdy_i = 1'b1;
        xact(1'b1, 1, 4'h4, 32'h0, 1'b0);
        drdy_i = 1'b0;
        xact(1'b1, 1, 4'h4, 32'h0, 1'b0);

        // R10 parallel result load
        res_i = 24'hA5C3E1;
        @(negedge clk) res_vld_i = 1'b1;
        @(negedge clk) res_vld_i = 1'b0;
        mem[0] = 8'hA5; mem[1] = 8'hC3; mem[2] = 8'hE1;
        xact(1'b1, 3, 4'h0, 32'h0, 1'b0);

        // R2 back-to-back transactions with select held low
        xact(1'b0, 1, 4'h9, 32'h6D00_0000, 1'b1);
        xact(1'b1, 1, 4'h9, 32'h0, 1'b1);
        xact(1'b0, 2, 4'hD, 32'h4E7A_0000, 1'b1);
        xact(1'b1, 2, 4'hD, 32'h0, 1'b0);

        // R9 abort inside an instruction, then inside a data byte
        begin
            logic o;
            cs_n = 1'b0;
            for (int i = 0; i < 5; i++) sbit(1'b1, o);
            cs_n = 1'b1;
            repeat (3) @(negedge clk);
            xact(1'b1, 1, 4'h7, 32'h0, 1'b0);
            cs_n = 1'b0;
            for (int i = 7; i >= 0; i--) sbit(i == 3, o);   // write 1 byte at 0x8
            for (int i = 0; i < 4; i++) sbit(1'b1, o);
            cs_n = 1'b1;
            repeat (3) @(negedge clk);
            check_regs("R9 partial write discarded");
            xact(1'b1, 1, 4'h8, 32'h0, 1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule